// File: doc/BRIEF.md
# Read-Sequence Command Decoder

This block sits beside an asynchronous SRAM-style memory and watches its control strobes and address bus, after registering them into a system clock domain. Software can trigger hidden maintenance operations without any extra pins. It does this by issuing six reads in a row to a fixed list of addresses. The first five addresses form a fixed unlock key. The sixth address picks one of four actions: a nonvolatile store, a nonvolatile recall, switching the autostore feature on, or switching it off.

Store and recall are reported as one-cycle request pulses to the nonvolatile controller. That controller is outside this block; it answers through a `busy` input while its operation runs. The autostore setting is kept here as a level output. The block also produces the registered output-enable for the memory data bus. This signal is low while the device is deselected, during writes, during the final read of a store or recall command, and while the controller is busy.

Top module: `seqcmd_decoder`

## Requirements
- R1: Reads of 16-bit keys 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F in that order, followed by a read of 0x8FC0, produce `store_req` high for exactly one clock cycle.
- R2: The same five-key prefix followed by a read of 0x4C63 produces `recall_req` high for exactly one clock cycle. `store_req` and `recall_req` are never high together.
- R3: After the prefix, a sixth read of 0x4B46 sets `auto_en` to 1 and a sixth read of 0x8B45 clears it. `auto_en` is 1 after reset and changes only on these two commands.
- R4: Only address bits 15:0 are compared with the keys. Bit 16 may hold any value on any step.
- R5: While `ce_n` is high, no step is counted and `dout_en` is 0. A partial sequence survives a deselect period, even when the address moves during that period.
- R6: A cycle with `ce_n` low and `we_n` low returns the matcher to idle, and `dout_en` is 0 for that cycle.
- R7: A read that does not match the expected step returns the matcher to idle. If its key is 0x4E38, that read counts as a new first step.
- R8: A step is counted on the falling edge of `ce_n`, or on a change of any address line while `ce_n` stays low. An address held steady counts only once.
- R9: `dout_en` is 1 for a read (`ce_n` low, `we_n` high, `oe_n` low) while not busy. The exception is the final read of a store or recall command, which gives 0 until the next step or deselect. Autostore commands still give 1.
- R10: While `busy` is high, reads are not counted, the matcher returns to idle and `dout_en` is 0.
- R11: `ce_n`, `we_n`, `oe_n`, `addr` and `busy` are registered once. All outputs change on the second rising clock edge after an input change. The reset state is `store_req`=0, `recall_req`=0, `dout_en`=0, `auto_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Memory address bus |
| busy | input | 1 | Nonvolatile controller busy |
| store_req | output | 1 | One-cycle nonvolatile store request |
| recall_req | output | 1 | One-cycle nonvolatile recall request |
| auto_en | output | 1 | Autostore enabled flag |
| dout_en | output | 1 | Data bus output enable |

## Verification
Every result of this block is due on the second rising edge after the bench changes the bus. The first edge captures the inputs. The second edge evaluates the step and updates the request pulses, the autostore flag and the output enable. The bench drives each access on a falling edge, waits exactly two rising edges, and samples 5 ns later. This catches a request pulse inside its single cycle. Held-address and deselect phases are sampled one cycle later, to confirm that no late pulse follows.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;
  localparam int KEY_W = 16;
  localparam int STEPS = 6;
  localparam int POS_W = $clog2(STEPS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(STEPS - 1);

  typedef enum logic [2:0] {
    CMD_NONE, CMD_STORE, CMD_RECALL, CMD_AUTO_ON, CMD_AUTO_OFF
  } cmd_e;

  function automatic logic [KEY_W-1:0] prefix_key(input logic [POS_W-1:0] pos);
    case (pos)
      3'd0: prefix_key = 16'h4E38;
      3'd1: prefix_key = 16'hB1C7;
      3'd2: prefix_key = 16'h83E0;
      3'd3: prefix_key = 16'h7C1F;
      3'd4: prefix_key = 16'h703F;
      default: prefix_key = 16'h0000;
    endcase
  endfunction

  function automatic cmd_e final_cmd(input logic [KEY_W-1:0] key);
    case (key)
      16'h8FC0: final_cmd = CMD_STORE;
      16'h4C63: final_cmd = CMD_RECALL;
      16'h4B46: final_cmd = CMD_AUTO_ON;
      16'h8B45: final_cmd = CMD_AUTO_OFF;
      default:  final_cmd = CMD_NONE;
    endcase
  endfunction
endpackage

// File: rtl/seqcmd_sampler.sv
module seqcmd_sampler #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              s_ce_n,
  output logic              s_busy,
  output logic              rd_drive,
  output logic              step,
  output logic              abort,
  output logic [seqcmd_pkg::KEY_W-1:0] key
);
  import seqcmd_pkg::*;

  logic              s_we_n, s_oe_n, p_ce_n;
  logic [ADDR_W-1:0] s_addr, p_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_busy <= 1'b0;
      s_addr <= '0;
      p_ce_n <= 1'b1;
      p_addr <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_busy <= busy;
      s_addr <= addr;
      p_ce_n <= s_ce_n;
      p_addr <= s_addr;
    end
  end

  // a step opens on chip-enable fall or any address line moving while selected
  always_comb begin
    key      = s_addr[KEY_W-1:0];
    abort    = s_busy || (!s_ce_n && !s_we_n);
    step     = !s_ce_n && s_we_n && !s_busy && (p_ce_n || (s_addr != p_addr));
    rd_drive = !s_ce_n && s_we_n && !s_oe_n && !s_busy;
  end

  AST_STEP_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    step |-> !abort);  // R8
  AST_HELD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (!s_ce_n && !p_ce_n && $stable(s_addr)) |-> !step);  // R8
endmodule

// File: rtl/seqcmd_matcher.sv
module seqcmd_matcher
  import seqcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             abort,
  input  logic [KEY_W-1:0] key,
  output cmd_e             hit
);
  logic [POS_W-1:0] pos_q, pos_n;

  always_comb begin
    hit   = CMD_NONE;
    pos_n = pos_q;
    if (abort) begin
      pos_n = '0;
    end else if (step) begin
      if (pos_q == LAST_POS) hit = final_cmd(key);
      if (pos_q != LAST_POS && key == prefix_key(pos_q))
        pos_n = pos_q + 1'b1;
      else if (hit != CMD_NONE)
        pos_n = '0;
      else
        pos_n = (key == prefix_key('0)) ? POS_W'(1) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= '0;
    else     pos_q <= pos_n;
  end

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos_q <= LAST_POS);  // R1
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> pos_q == '0);  // R6
  AST_NO_STEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !abort) |=> $stable(pos_q));  // R5
endmodule

// File: rtl/seqcmd_decoder.sv
module seqcmd_decoder
  import seqcmd_pkg::*;
#(
  parameter int   ADDR_W    = 17,
  parameter logic AUTO_INIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  output logic              store_req,
  output logic              recall_req,
  output logic              auto_en,
  output logic              dout_en
);
  logic             s_ce_n, s_busy, rd_drive, step, abort, hiz_q, hiz_now;
  logic [KEY_W-1:0] key;
  cmd_e             hit;

  seqcmd_sampler #(.ADDR_W(ADDR_W)) u_sampler (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .busy(busy), .s_ce_n(s_ce_n), .s_busy(s_busy),
    .rd_drive(rd_drive), .step(step), .abort(abort), .key(key)
  );

  seqcmd_matcher u_matcher (
    .clk(clk), .rst(rst), .step(step), .abort(abort), .key(key), .hit(hit)
  );

  // store/recall keep the data bus quiet until the next step or deselect
  always_comb
    hiz_now = (hit == CMD_STORE) || (hit == CMD_RECALL) ||
              (hiz_q && !step && !s_ce_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
      auto_en    <= AUTO_INIT;
      dout_en    <= 1'b0;
      hiz_q      <= 1'b0;
    end else begin
      store_req  <= (hit == CMD_STORE);
      recall_req <= (hit == CMD_RECALL);
      if (hit == CMD_AUTO_ON)  auto_en <= 1'b1;
      if (hit == CMD_AUTO_OFF) auto_en <= 1'b0;
      hiz_q      <= hiz_now;
      dout_en    <= rd_drive && !hiz_now;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(store_req && recall_req));  // R2
  AST_STORE_PULSE: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);  // R1
  AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);  // R2
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(hit == CMD_NONE) |-> $stable(auto_en));  // R3
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(s_ce_n) |-> (!dout_en && !store_req && !recall_req));  // R5
  AST_BUSY_HIZ: assert property (@(posedge clk) disable iff (rst)
    $past(s_busy) |-> !dout_en);  // R10
  AST_REQ_HIZ: assert property (@(posedge clk) disable iff (rst)
    (store_req || recall_req) |-> !dout_en);  // R9
endmodule

// File: tb/seqcmd_decoder_test.sv
module seqcmd_decoder_test;
  logic        clk = 1'b0, rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
  logic [16:0] addr = '0;
  logic        store_req, recall_req, auto_en, dout_en;
  int          checks = 0, errors = 0;
  int          m_pos = 0;
  bit          m_auto = 1'b1, done = 1'b0;
  bit          e_store, e_recall, e_drive;

  seqcmd_decoder uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .busy(busy), .store_req(store_req), .recall_req(recall_req),
    .auto_en(auto_en), .dout_en(dout_en)
  );

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [15:0] f_prefix(int i);
    case (i)
      0: return 16'h4E38; 1: return 16'hB1C7; 2: return 16'h83E0;
      3: return 16'h7C1F; 4: return 16'h703F; default: return 16'h0000;
    endcase
  endfunction

  // 1 store, 2 recall, 3 auto on, 4 auto off
  function automatic int f_cmd(logic [15:0] k);
    case (k)
      16'h8FC0: return 1; 16'h4C63: return 2;
      16'h4B46: return 3; 16'h8B45: return 4; default: return 0;
    endcase
  endfunction

  function automatic void model(bit we, bit oe, bit bz, logic [15:0] k);
    int c = 0;
    e_store = 0; e_recall = 0; e_drive = 0;
    if (bz || !we) begin m_pos = 0; return; end
    if (m_pos == 5) c = f_cmd(k);
    if (m_pos < 5 && k == f_prefix(m_pos)) m_pos++;
    else if (c != 0) m_pos = 0;
    else m_pos = (k == f_prefix(0)) ? 1 : 0;
    e_store  = (c == 1);
    e_recall = (c == 2);
    if (c == 3) m_auto = 1;
    if (c == 4) m_auto = 0;
    e_drive = !oe && c != 1 && c != 2;
  endfunction

  task automatic chk(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "store_req", store_req, e_store);
    chk(tag, "recall_req", recall_req, e_recall);
    chk(tag, "auto_en", auto_en, m_auto);
    chk(tag, "dout_en", dout_en, e_drive);
  endtask

  // desel=1: one deselected cycle first, so the step comes from ce_n falling
  task automatic access(string tag, bit desel, bit we, bit oe, bit bz, logic [16:0] a);
    if (desel) begin
      @(negedge clk); ce_n = 1'b1; busy = bz;
      @(posedge clk);
    end
    @(negedge clk);
    ce_n = 1'b0; we_n = we; oe_n = oe; addr = a; busy = bz;
    model(we, oe, bz, a[15:0]);
    @(posedge clk); @(posedge clk); #5;
    check_all(tag);
  endtask

  task automatic prefix_run(string tag, int upto, bit desel);
    for (int i = 0; i < upto; i++) access(tag, desel, 1, 0, 0, {1'b0, f_prefix(i)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #5;
    chk("R11", "reset store_req", store_req, 0);
    chk("R11", "reset recall_req", recall_req, 0);
    chk("R3", "reset auto_en", auto_en, 1);
    chk("R11", "reset dout_en", dout_en, 0);

    // R1 store, then pulse must be gone one cycle later
    prefix_run("R1", 5, 1);
    access("R1", 1, 1, 0, 0, 17'h08FC0);
    @(posedge clk); #5;
    chk("R1", "store pulse width", store_req, 0);
    chk("R9", "store hiz held", dout_en, 0);

    // R2 recall with bit 16 set on several steps (R4)
    for (int i = 0; i < 5; i++) access("R4", 1, 1, 0, 0, {i[0], f_prefix(i)});
    access("R2", 1, 1, 0, 0, 17'h14C63);

    // R3 / R9 autostore off then on, data still driven
    prefix_run("R3", 5, 1);
    access("R3", 1, 1, 0, 0, 17'h08B45);
    chk("R9", "auto cmd drives", dout_en, 1);
    prefix_run("R3", 5, 1);
    access("R3", 1, 1, 0, 0, 17'h04B46);

    // R6 write in the middle aborts
    prefix_run("R6", 3, 1);
    access("R6", 1, 0, 0, 0, {1'b0, f_prefix(3)});
    for (int i = 3; i < 5; i++) access("R6", 1, 1, 0, 0, {1'b0, f_prefix(i)});
    access("R6", 1, 1, 0, 0, 17'h08FC0);

    // R7 mismatch on 0x4E38 restarts as step one
    prefix_run("R7", 2, 1);
    access("R7", 1, 1, 0, 0, 17'h04E38);
    for (int i = 1; i < 5; i++) access("R7", 1, 1, 0, 0, {1'b0, f_prefix(i)});
    access("R7", 1, 1, 0, 0, 17'h04C63);

    // R5 deselect with wandering address keeps a partial sequence
    prefix_run("R5", 3, 1);
    @(negedge clk); ce_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); addr = {1'b0, f_prefix(i)};
      @(posedge clk); @(posedge clk); #5;
      chk("R5", "deselect dout_en", dout_en, 0);
      chk("R5", "deselect store_req", store_req, 0);
    end
    for (int i = 3; i < 5; i++) access("R5", 1, 1, 0, 0, {1'b0, f_prefix(i)});
    access("R5", 1, 1, 0, 0, 17'h08FC0);

    // R8 address changes with ce_n held low, with a held step
    access("R8", 1, 1, 0, 0, {1'b0, f_prefix(0)});
    for (int i = 1; i < 5; i++) access("R8", 0, 1, 0, 0, {1'b0, f_prefix(i)});
    repeat (3) @(posedge clk); #5;
    chk("R8", "held no pulse", store_req, 0);
    access("R8", 0, 1, 0, 0, 17'h08FC0);

    // R10 busy aborts and blocks data
    prefix_run("R10", 3, 1);
    access("R10", 1, 1, 0, 1, {1'b0, f_prefix(3)});
    for (int i = 3; i < 5; i++) access("R10", 1, 1, 0, 0, {1'b0, f_prefix(i)});
    access("R10", 1, 1, 0, 0, 17'h04C63);

    // constrained random mix
    void'($urandom(32'h5EC0DE));
    for (int n = 0; n < 800; n++) begin
      logic [16:0] a;
      int sel = $urandom_range(0, 99);
      bit we  = ($urandom_range(0, 99) >= 5);
      bit bz  = ($urandom_range(0, 99) < 4);
      bit oe  = ($urandom_range(0, 99) < 20);
      bit ds  = $urandom_range(0, 1);
      if (sel < 65) a[15:0] = (m_pos < 5) ? f_prefix(m_pos)
                                          : 16'(case_final($urandom_range(0, 3)));
      else if (sel < 80) a[15:0] = f_prefix($urandom_range(0, 4));
      else a[15:0] = 16'($urandom);
      a[16] = $urandom_range(0, 1);
      if (a[15:0] == addr[15:0]) ds = 1;
      access("R11", ds, we, oe, bz, a);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [15:0] case_final(int i);
    case (i)
      0: return 16'h8FC0; 1: return 16'h4C63;
      2: return 16'h4B46; default: return 16'h8B45;
    endcase
  endfunction
endmodule